// File: doc/BRIEF.md
# Board Reset and Bus Isolation Timing Supervisor

This block drives the system reset and the data-bus isolation control of a hot-pluggable board. It watches a power-good flag for the low supply rail, two connector-sense inputs, a reset request, two undervoltage flags and a latched overcurrent flag. From these it produces an active-low system reset and an active-high bus-disable signal, which move together.

Any hard cause (a connector-sense input high, the request low, either undervoltage flag, or the overcurrent flag) forces reset one clock later. Release is slow. Power-good must stay high, with no hard cause present, for a long settling window (200 ms by default) before reset and bus isolation let go. Loss of power-good acts quickly but is filtered: reset follows only after power-good has stayed low for a short window (32 µs by default).

Each window is a count of microsecond ticks derived from the clock. Both tick lengths are parameters, so a bench can run with short windows.

Top module: `rbs_supervisor`

## Requirements
- R1: While rst_n is low and after it is released, sys_rst_n is 0 and bus_dis is 1 until a release occurs.
- R2: If conn_a is 1, conn_b is 1, rst_req_n is 0, uvlo_lo is 1, uvlo_hi is 1 or ovc_fault is 1 at a clock edge, then after that edge sys_rst_n is 0 and bus_dis is 1.
- R3: While in reset, once pgood is 1 and no hard cause is present at RELEASE_US*CLK_PER_US consecutive edges, the next edge releases: sys_rst_n becomes 1 and bus_dis becomes 0.
- R4: A hard cause during the release window restarts the window from zero once the cause clears.
- R5: A pgood drop during the release window restarts the window from zero on the next rise.
- R6: While released, if pgood is 0 at ASSERT_US*CLK_PER_US consecutive edges, the next edge asserts reset.
- R7: While released with no hard cause, a pgood low pulse shorter than ASSERT_US*CLK_PER_US cycles leaves sys_rst_n at 1 and bus_dis at 0.
- R8: bus_dis is always the complement of sys_rst_n.
- R9: Once released, the outputs stay released for as long as pgood stays 1 and no hard cause appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pgood | input | 1 | Low-supply power-good flag |
| conn_a | input | 1 | Connector sense A, 1 = not mated |
| conn_b | input | 1 | Connector sense B, 1 = not mated |
| rst_req_n | input | 1 | Reset request, active low |
| uvlo_lo | input | 1 | Low-rail undervoltage lockout |
| uvlo_hi | input | 1 | High-rail undervoltage lockout |
| ovc_fault | input | 1 | Latched overcurrent fault |
| sys_rst_n | output | 1 | System reset, active low |
| bus_dis | output | 1 | Data-bus isolation, active high |

## Verification
A wrong tick prescaler or tick counter in either window moves the release or assertion edge by at least one cycle. The bench compares outputs on every cycle against its own timing model, so this shows up at the exact edge where release was due. A state bit stuck in either value shows within one cycle of the next hard cause or release. A window counter that fails to clear shows as an early release after a pgood drop, or as a spurious assertion after a short glitch.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

    // Registered state of the supervisor core.
    typedef struct packed {
        logic rst_on;   // 1 = reset and bus isolation asserted
    } sup_state_t;

endpackage

// File: rtl/rbs_cause.sv
// Combines the independent immediate reset causes into one flag.
module rbs_cause (
    input  logic conn_a,
    input  logic conn_b,
    input  logic rst_req_n,
    input  logic uvlo_lo,
    input  logic uvlo_hi,
    input  logic ovc_fault,
    output logic hard
);
    always_comb begin
        hard = conn_a | conn_b | ~rst_req_n | uvlo_lo | uvlo_hi | ovc_fault;
    end
endmodule

// File: rtl/rbs_delay.sv
// Windowed delay: done rises after TICKS*CYC_PER_TICK consecutive edges
// with run high, holds while run stays high, and clears when run drops.
module rbs_delay #(
    parameter int CYC_PER_TICK = 100,
    parameter int TICKS        = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int PW = $clog2(CYC_PER_TICK + 1);
    localparam int CW = $clog2(TICKS + 1);

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [CW-1:0] cnt;
        logic          done;
    } tmr_t;

    tmr_t tmr_q, tmr_d;

    always_comb begin
        tmr_d = tmr_q;
        if (!run) begin
            tmr_d = '0;
        end else if (!tmr_q.done) begin
            if (tmr_q.pre == PW'(CYC_PER_TICK - 1)) begin
                tmr_d.pre = '0;
                if (tmr_q.cnt == CW'(TICKS - 1)) begin
                    tmr_d.done = 1'b1;
                end else begin
                    tmr_d.cnt = tmr_q.cnt + 1'b1;
                end
            end else begin
                tmr_d.pre = tmr_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign done = tmr_q.done;

    // R5
    tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt < CW'(TICKS));

    // R5
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(run));

    // R4
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !done);
endmodule

// File: rtl/rbs_supervisor.sv
module rbs_supervisor #(
    parameter int CLK_PER_US = 100,
    parameter int RELEASE_US = 200000,
    parameter int ASSERT_US  = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pgood,
    input  logic conn_a,
    input  logic conn_b,
    input  logic rst_req_n,
    input  logic uvlo_lo,
    input  logic uvlo_hi,
    input  logic ovc_fault,
    output logic sys_rst_n,
    output logic bus_dis
);
    import rbs_pkg::*;

    logic       hard;
    logic       run_rel, run_ast;
    logic       done_rel, done_ast;
    sup_state_t st_q, st_d;

    rbs_cause u_cause (
        .conn_a    (conn_a),
        .conn_b    (conn_b),
        .rst_req_n (rst_req_n),
        .uvlo_lo   (uvlo_lo),
        .uvlo_hi   (uvlo_hi),
        .ovc_fault (ovc_fault),
        .hard      (hard)
    );

    // Release window: runs only while in reset with clean conditions.
    assign run_rel = st_q.rst_on & pgood & ~hard;
    // Assertion filter: runs only while released and power-good is lost.
    assign run_ast = ~st_q.rst_on & ~pgood;

    rbs_delay #(
        .CYC_PER_TICK (CLK_PER_US),
        .TICKS        (RELEASE_US)
    ) u_rel (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_rel),
        .done  (done_rel)
    );

    rbs_delay #(
        .CYC_PER_TICK (CLK_PER_US),
        .TICKS        (ASSERT_US)
    ) u_ast (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_ast),
        .done  (done_ast)
    );

    always_comb begin
        st_d = st_q;
        if (hard) begin
            st_d.rst_on = 1'b1;
        end else if (st_q.rst_on) begin
            st_d.rst_on = ~done_rel;
        end else begin
            st_d.rst_on = done_ast;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rst_on <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sys_rst_n = ~st_q.rst_on;
    assign bus_dis   = st_q.rst_on;

    // R2
    cause_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hard |=> !sys_rst_n);

    // R3
    release_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> (!$past(hard) && $past(pgood, 2)));

    // R6
    assert_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_n) |-> ($past(hard) || !$past(pgood, 2)));

    // R9
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_n && pgood && !hard) |=> sys_rst_n);
endmodule

// File: tb/tb_rbs_supervisor.sv
module tb_rbs_supervisor;
    localparam int CPU = 4;
    localparam int REL = 25;
    localparam int AST = 5;
    localparam int NREL = CPU * REL;
    localparam int NAST = CPU * AST;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pgood;
    logic [5:0] cause;
    logic       sys_rst_n, bus_dis;

    int    n_run = 0;
    int    n_fail = 0;
    string cur = "R1";
    bit    checking = 1'b0;

    // Expected-behaviour model state.
    logic exp_on;
    int   rel_cnt, low_cnt;

    always #5 clk = ~clk;

    rbs_supervisor #(
        .CLK_PER_US (CPU),
        .RELEASE_US (REL),
        .ASSERT_US  (AST)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pgood     (pgood),
        .conn_a    (cause[0]),
        .conn_b    (cause[1]),
        .rst_req_n (~cause[2]),
        .uvlo_lo   (cause[3]),
        .uvlo_hi   (cause[4]),
        .ovc_fault (cause[5]),
        .sys_rst_n (sys_rst_n),
        .bus_dis   (bus_dis)
    );

    function automatic logic f_on(logic on, logic h, int rc, int lc);
        if (h) return 1'b1;
        if (on) return (rc < NREL);
        return (lc >= NAST);
    endfunction

    function automatic int f_rel(logic on, logic h, logic pg, int rc);
        if (on && pg && !h) return (rc < NREL) ? rc + 1 : NREL;
        return 0;
    endfunction

    function automatic int f_low(logic on, logic pg, int lc);
        if (!on && !pg) return (lc < NAST) ? lc + 1 : NAST;
        return 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_on  <= 1'b1;
            rel_cnt <= 0;
            low_cnt <= 0;
        end else begin
            exp_on  <= f_on(exp_on, |cause, rel_cnt, low_cnt);
            rel_cnt <= f_rel(exp_on, |cause, pgood, rel_cnt);
            low_cnt <= f_low(exp_on, pgood, low_cnt);
        end
    end

    task automatic chk(string req, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (checking) begin
            chk(cur, sys_rst_n, ~exp_on);
            // R8
            chk("R8", bus_dis, ~sys_rst_n);
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        pgood = 1'b0;
        cause = '0;
        @(negedge clk);
        checking = 1'b1;
        // R1: reset state
        chk("R1", sys_rst_n, 1'b0);
        chk("R1", bus_dis, 1'b1);
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(5);
        chk("R1", sys_rst_n, 1'b0);

        // R3: release after the full window
        cur = "R3";
        pgood = 1'b1;
        wait_cyc(NREL);
        chk("R3", sys_rst_n, 1'b0);
        wait_cyc(1);
        chk("R3", sys_rst_n, 1'b1);
        wait_cyc(10);

        // R7: short glitch ignored
        cur = "R7";
        pgood = 1'b0;
        wait_cyc(NAST - 2);
        pgood = 1'b1;
        wait_cyc(5);
        chk("R7", sys_rst_n, 1'b1);
        wait_cyc(20);

        // R6: long loss asserts
        cur = "R6";
        pgood = 1'b0;
        wait_cyc(NAST + 3);
        chk("R6", sys_rst_n, 1'b0);

        // R5: drop inside the window restarts it
        cur = "R5";
        pgood = 1'b1;
        wait_cyc(60);
        pgood = 1'b0;
        wait_cyc(2);
        pgood = 1'b1;
        wait_cyc(NREL - 5);
        chk("R5", sys_rst_n, 1'b0);
        wait_cyc(10);
        chk("R5", sys_rst_n, 1'b1);

        // R2: each hard cause on its own
        cur = "R2";
        for (int i = 0; i < 6; i++) begin
            cause = 6'(1 << i);
            wait_cyc(1);
            chk("R2", sys_rst_n, 1'b0);
            wait_cyc(1);
            cause = '0;
            wait_cyc(NREL + 5);
        end

        // R4: hard cause inside the window restarts it
        cur = "R4";
        cause[3] = 1'b1;
        wait_cyc(2);
        cause = '0;
        wait_cyc(70);
        cause[5] = 1'b1;
        wait_cyc(1);
        cause = '0;
        wait_cyc(NREL - 10);
        chk("R4", sys_rst_n, 1'b0);
        wait_cyc(15);
        chk("R4", sys_rst_n, 1'b1);

        // R9: stays released
        cur = "R9";
        wait_cyc(200);
        chk("R9", sys_rst_n, 1'b1);

        // Random mix, checked every cycle against the model
        cur = "R2";
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(0, 39) == 0) pgood = ~pgood;
            for (int i = 0; i < 6; i++) begin
                if (cause[i]) begin
                    if ($urandom_range(0, 7) == 0) cause[i] = 1'b0;
                end else if ($urandom_range(0, 299) == 0) begin
                    cause[i] = 1'b1;
                end
            end
            wait_cyc(1);
        end

        checking = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule